// File: doc/BRIEF.md
# Received FEC Pad Format Monitor

This block inspects the short pad field that arrives with every received FEC frame and works out which of two frame formats the far end is transmitting. The older format sends one fixed base value on one frame and its bitwise inverse on the next. The newer format has its own base value and keeps each polarity for a configurable run of frames before inverting. Both base values and both run lengths are parameters. A link can keep framing and re-framing while its PCS never locks. In that case the monitor tells the user that the far end is set to the other format.

The monitor runs one phase tracker per format. Each tracker takes its polarity and run position from the first in-set pad it sees. It then predicts every later pad and votes for its format when the prediction holds. A run counter declares the detected format once enough consecutive frames vote for the same format. A sticky flag records a detected format that differs from the locally configured one. A loss-of-frame input restarts detection. If the parameters make the two formats overlap, a frame that satisfies both trackers neither extends nor breaks the run.

Top module: `fec_pad_monitor`

## Requirements
- R1: After reset, `fmt_locked`, `fmt_is_new` and `fmt_mismatch` are all 0.
- R2: With the default legacy base 5'b00101, the legacy sequence alternates 00101 and 11010 on every frame. `fmt_locked` rises with `fmt_is_new` = 0 after the clock edge that samples the 8th consecutive agreeing frame, and not before.
- R3: With the default new base 5'b01110, the new sequence holds each polarity for 2 frames (01110, 01110, 10001, 10001, ...). Eight consecutive agreeing frames lock with `fmt_is_new` = 1.
- R4: The expected polarity and run position come from the first in-set pad after reset or loss of frame, and either polarity is accepted. If a sequence starts in the middle of a run, the first misprediction restarts the phase without a vote, so lock is delayed by 2 frames.
- R5: A frame that breaks the run clears the count, and 8 new agreeing frames are then needed. Such a frame is either a pad outside both formats' value sets or an in-set pad of the wrong polarity. A pad outside a format's set also drops that tracker's phase, and the next in-set pad re-takes the phase and counts.
- R6: Once locked, `fmt_locked` stays 1 until loss of frame. `fmt_is_new` changes only after 8 consecutive frames agree with the other format.
- R7: `fmt_mismatch` is set on the cycle after `fmt_locked` = 1 while `fmt_is_new` differs from `local_fmt` (0 legacy, 1 new). It is sticky. A `stat_rd` pulse clears it only if the condition no longer holds.
- R8: `lof` clears the lock, the detected format, the run count and both phases on the next edge. A frame strobed in the same cycle as `lof` is ignored, and `lof` leaves `fmt_mismatch` unchanged.
- R9: Cycles with `frame_vld` low have no effect, whatever value `pad_in` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | One-cycle strobe marking a received frame's pad |
| pad_in | input | PAD_W | Received pad field |
| local_fmt | input | 1 | Locally configured format, 0 legacy, 1 new |
| lof | input | 1 | Loss of frame, restarts detection |
| stat_rd | input | 1 | Management read strobe of the status bits |
| fmt_locked | output | 1 | A format has been declared |
| fmt_is_new | output | 1 | Declared format, 0 legacy, 1 new |
| fmt_mismatch | output | 1 | Sticky: declared format differed from `local_fmt` |

## Verification
Both formats are swept over every starting offset within their inversion cycle. This separates aligned starts, which lock on exactly the 8th frame, from mid-run starts, which lock 2 frames later. A second sweep places a foreign pad, or a repeated pad of the wrong polarity, at each position of the first run, so that the lock frame moves by exactly the error position. Switching formats while locked, and loss of frame arriving together with a frame strobe, check that the lock is held and that a restart drops the strobe. The mismatch flag is set, read while still valid, then read after the lock is gone, to tell sticky behaviour apart from clear-on-read. Idle cycles carry in-set pad values throughout, so that a design sampling without the strobe is caught.

// File: rtl/fec_pad_pkg.sv
package fec_pad_pkg;

    typedef enum logic {
        FMT_LEGACY = 1'b0,
        FMT_NEW    = 1'b1
    } pad_fmt_e;

    // Number of format trackers run side by side.
    localparam int unsigned NUM_FMT = 2;

endpackage

// File: rtl/fec_pad_phase_track.sv
// Tracks the inversion phase of one pad format and votes on every frame.
module fec_pad_phase_track #(
    parameter int unsigned          PAD_W    = 5,
    parameter logic [PAD_W-1:0]     BASE_PAD = '0,
    parameter int unsigned          RUN_LEN  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             frame_vld,
    input  logic [PAD_W-1:0] pad,
    output logic             agree
);
    localparam int unsigned      POS_W    = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(RUN_LEN - 1);

    typedef struct packed {
        logic             has_phase;
        logic             pol;
        logic [POS_W-1:0] pos;
    } trk_t;

    trk_t             trk_q, trk_d;
    logic [PAD_W-1:0] exp_pad;
    logic             take;
    logic             cur_pol;
    logic [POS_W-1:0] cur_pos;

    always_comb begin
        trk_d   = trk_q;
        agree   = 1'b0;
        take    = 1'b0;
        cur_pol = trk_q.pol;
        cur_pos = trk_q.pos;
        exp_pad = BASE_PAD ^ {PAD_W{trk_q.pol}};
        if (clr) begin
            trk_d = '0;
        end else if (frame_vld) begin
            if (trk_q.has_phase && (pad == exp_pad)) begin
                agree = 1'b1;
                take  = 1'b1;
            end else if ((pad == BASE_PAD) || (pad == ~BASE_PAD)) begin
                // first pad of a phase counts only when no phase was held
                agree   = ~trk_q.has_phase;
                take    = 1'b1;
                cur_pol = (pad != BASE_PAD);
                cur_pos = '0;
            end else begin
                trk_d = '0;
            end
            if (take) begin
                trk_d.has_phase = 1'b1;
                if (cur_pos == LAST_POS) begin
                    trk_d.pos = '0;
                    trk_d.pol = ~cur_pol;
                end else begin
                    trk_d.pos = cur_pos + 1'b1;
                    trk_d.pol = cur_pol;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

endmodule

// File: rtl/fec_pad_run_ctr.sv
// Counts consecutive frames voting for one format and declares it.
module fec_pad_run_ctr
    import fec_pad_pkg::*;
#(
    parameter int unsigned AGREE_CNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic frame_vld,
    input  logic vote_legacy,
    input  logic vote_new,
    output logic locked,
    output logic is_new
);
    localparam int unsigned      CNT_W     = $clog2(AGREE_CNT + 1);
    localparam logic [CNT_W-1:0] AGREE_MAX = CNT_W'(AGREE_CNT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        pad_fmt_e         cand;
        logic             locked;
        pad_fmt_e         fmt;
    } run_t;

    run_t     run_q, run_d;
    pad_fmt_e vote_fmt;

    always_comb begin
        run_d    = run_q;
        vote_fmt = vote_new ? FMT_NEW : FMT_LEGACY;
        if (clr) begin
            run_d = '0;
        end else if (frame_vld) begin
            if (vote_legacy && vote_new) begin
                run_d.cnt = run_q.cnt;
            end else if (vote_legacy || vote_new) begin
                if ((run_q.cnt != '0) && (run_q.cand == vote_fmt)) begin
                    run_d.cnt = (run_q.cnt == AGREE_MAX) ? run_q.cnt : run_q.cnt + 1'b1;
                end else begin
                    run_d.cnt  = CNT_W'(1);
                    run_d.cand = vote_fmt;
                end
            end else begin
                run_d.cnt = '0;
            end
            if (run_d.cnt == AGREE_MAX) begin
                run_d.locked = 1'b1;
                run_d.fmt    = run_d.cand;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign locked = run_q.locked;
    assign is_new = (run_q.fmt == FMT_NEW);

endmodule

// File: rtl/fec_pad_monitor.sv
module fec_pad_monitor
    import fec_pad_pkg::*;
#(
    parameter int unsigned      PAD_W      = 5,
    parameter logic [PAD_W-1:0] LEGACY_PAD = 5'b00101,
    parameter int unsigned      LEGACY_RUN = 1,
    parameter logic [PAD_W-1:0] NEW_PAD    = 5'b01110,
    parameter int unsigned      NEW_RUN    = 2,
    parameter int unsigned      AGREE_CNT  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_vld,
    input  logic [PAD_W-1:0] pad_in,
    input  logic             local_fmt,
    input  logic             lof,
    input  logic             stat_rd,
    output logic             fmt_locked,
    output logic             fmt_is_new,
    output logic             fmt_mismatch
);
    typedef struct packed {
        logic mismatch;
    } stat_t;

    logic [NUM_FMT-1:0] votes;
    logic               locked_w;
    logic               is_new_w;
    stat_t              stat_q, stat_d;

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_trk
        fec_pad_phase_track #(
            .PAD_W    (PAD_W),
            .BASE_PAD ((g == 0) ? LEGACY_PAD : NEW_PAD),
            .RUN_LEN  ((g == 0) ? LEGACY_RUN : NEW_RUN)
        ) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (lof),
            .frame_vld (frame_vld),
            .pad       (pad_in),
            .agree     (votes[g])
        );
    end

    fec_pad_run_ctr #(
        .AGREE_CNT (AGREE_CNT)
    ) u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (lof),
        .frame_vld   (frame_vld),
        .vote_legacy (votes[0]),
        .vote_new    (votes[1]),
        .locked      (locked_w),
        .is_new      (is_new_w)
    );

    always_comb begin
        stat_d          = stat_q;
        stat_d.mismatch = (locked_w && (is_new_w != local_fmt))
                        || (stat_q.mismatch && !stat_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign fmt_locked   = locked_w;
    assign fmt_is_new   = is_new_w;
    assign fmt_mismatch = stat_q.mismatch;

endmodule

// File: rtl/fec_pad_monitor_chk.sv
module fec_pad_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_vld,
    input logic local_fmt,
    input logic lof,
    input logic stat_rd,
    input logic fmt_locked,
    input logic fmt_is_new,
    input logic fmt_mismatch
);
    p_lock_on_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fmt_locked) |-> ($past(frame_vld) && !$past(lof)));

    p_lock_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_locked && !lof) |=> fmt_locked);

    p_mismatch_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_locked && (fmt_is_new != local_fmt)) |=> fmt_mismatch);

    p_mismatch_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_mismatch && !stat_rd) |=> fmt_mismatch);

    p_lof_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lof |=> (!fmt_locked && !fmt_is_new));

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_vld && !lof) |=> ($stable(fmt_locked) && $stable(fmt_is_new)));

endmodule

bind fec_pad_monitor fec_pad_monitor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_vld    (frame_vld),
    .local_fmt    (local_fmt),
    .lof          (lof),
    .stat_rd      (stat_rd),
    .fmt_locked   (fmt_locked),
    .fmt_is_new   (fmt_is_new),
    .fmt_mismatch (fmt_mismatch)
);

// File: tb/fec_pad_monitor_bench.sv
module fec_pad_monitor_bench;
    localparam logic [4:0] LEG = 5'b00101;
    localparam logic [4:0] NEW = 5'b01110;
    localparam int         AGR = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_vld = 1'b0;
    logic [4:0] pad_in = 5'b0;
    logic       local_fmt = 1'b0;
    logic       lof = 1'b0;
    logic       stat_rd = 1'b0;
    logic       fmt_locked, fmt_is_new, fmt_mismatch;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fec_pad_monitor u_fec_pad_monitor (
        .clk (clk), .rst_n (rst_n), .frame_vld (frame_vld), .pad_in (pad_in),
        .local_fmt (local_fmt), .lof (lof), .stat_rd (stat_rd),
        .fmt_locked (fmt_locked), .fmt_is_new (fmt_is_new), .fmt_mismatch (fmt_mismatch)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Frame strobe, then one idle cycle carrying an in-set pad (R9 stimulus).
    task automatic send(input logic [4:0] p);
        @(negedge clk);
        frame_vld = 1'b1;
        pad_in    = p;
        @(negedge clk);
        frame_vld = 1'b0;
        pad_in    = ~p;
        @(negedge clk);
        pad_in    = LEG;
    endtask

    task automatic restart();
        @(negedge clk);
        lof = 1'b1;
        @(negedge clk);
        lof = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    function automatic logic [4:0] leg_pad(input int i);
        return (i % 2 == 1) ? ~LEG : LEG;
    endfunction

    function automatic logic [4:0] new_pad(input int i);
        return ((i / 2) % 2 == 1) ? ~NEW : NEW;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 lock in reset", fmt_locked, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 lock", fmt_locked, 1'b0);
        chk("R1 format", fmt_is_new, 1'b0);
        chk("R1 mismatch", fmt_mismatch, 1'b0);

        // R2 R3 R4 R9: every start offset of each format's inversion cycle
        for (int f = 0; f < 2; f++) begin
            for (int o = 0; o < (f == 0 ? 2 : 4); o++) begin
                int lk;
                local_fmt = f[0];
                restart();
                lk = AGR + ((f == 1 && (o % 2 == 1)) ? 2 : 0);
                for (int i = 0; i < 12; i++) begin
                    send(f == 0 ? leg_pad(i + o) : new_pad(i + o));
                    chk(f == 0 ? "R2 R4 legacy lock" : "R3 R4 new lock",
                        fmt_locked, (i + 1 >= lk));
                    if (i + 1 >= lk) chk("R2 R3 format", fmt_is_new, f[0]);
                end
            end
        end

        // R5: foreign pad at frame k, then wrong polarity at frame k
        local_fmt = 1'b0;
        for (int mode = 0; mode < 2; mode++) begin
            for (int k = (mode == 0 ? 1 : 2); k <= AGR; k++) begin
                logic pol;
                restart();
                pol = 1'b0;
                for (int i = 1; i <= k + AGR + 1; i++) begin
                    if (i == k && mode == 0) begin
                        send(5'b11111);
                    end else if (i == k) begin
                        pol = ~pol;
                        send(LEG ^ {5{pol}});
                        pol = ~pol;
                    end else begin
                        send(LEG ^ {5{pol}});
                        pol = ~pol;
                    end
                    chk(mode == 0 ? "R5 foreign pad" : "R5 wrong polarity",
                        fmt_locked, (i >= k + AGR));
                end
            end
        end

        // R6: switch while locked
        restart();
        rd_pulse();
        for (int i = 0; i < AGR; i++) send(leg_pad(i));
        chk("R6 legacy locked", fmt_locked, 1'b1);
        for (int i = 0; i < AGR; i++) begin
            send(new_pad(i));
            chk("R6 lock held", fmt_locked, 1'b1);
            chk("R6 format switch", fmt_is_new, (i == AGR - 1));
        end

        // R7 R8: mismatch sticky, read, loss of frame
        @(negedge clk);
        chk("R7 mismatch set", fmt_mismatch, 1'b1);
        rd_pulse();
        chk("R7 read while valid", fmt_mismatch, 1'b1);
        restart();
        chk("R8 lof unlock", fmt_locked, 1'b0);
        chk("R8 lof format", fmt_is_new, 1'b0);
        chk("R8 mismatch kept", fmt_mismatch, 1'b1);
        rd_pulse();
        chk("R7 read clears", fmt_mismatch, 1'b0);

        local_fmt = 1'b1;
        for (int i = 0; i < AGR; i++) send(new_pad(i));
        repeat (2) @(negedge clk);
        chk("R7 matching mode no mismatch", fmt_mismatch, 1'b0);
        local_fmt = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 mode change sets", fmt_mismatch, 1'b1);

        // R8: frame during lof is ignored
        @(negedge clk);
        lof = 1'b1;
        frame_vld = 1'b1;
        pad_in = LEG;
        @(negedge clk);
        lof = 1'b0;
        frame_vld = 1'b0;
        for (int i = 1; i < AGR; i++) send(leg_pad(i));
        chk("R8 frame with lof ignored", fmt_locked, 1'b0);
        send(leg_pad(AGR));
        chk("R8 lock after full run", fmt_locked, 1'b1);
        chk("R8 legacy format", fmt_is_new, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule